// File: doc/BRIEF.md
# DMA Channel Interrupt Status Aggregator

This block gathers per-channel event pulses from a multi-channel DMA engine and turns them into one interrupt line plus a small set of memory-mapped registers. Three independent event kinds are tracked for every channel: transfer done, error of the first kind and error of the second kind. Each kind owns a sticky pending latch, an enable mask and a masked view. A channel-indexed summary register flags every channel with at least one enabled pending event, and the OR of that summary, registered, is the interrupt output.

Software handles an interrupt by reading the summary and the masked views, then writing ones to the clear addresses of the kinds it has serviced. To stop a channel it writes that channel's bit to all three clear addresses. A channel priority word is held as plain read/write storage for the engine's arbiter. The register port has no handshake: a write takes effect on the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` combinationally. The reset is taken asynchronously and released through a two-stage synchronizer.

Top module: `dma_irq_agg`

## Requirements
- R1: While reset is asserted and after it is released, every register reads zero and `irq` is low, so all channels start masked.
- R2: A high bit i on `evt_done`, `evt_err1` or `evt_err2` at a clock edge sets bit i of that kind's pending latch, readable at 0x600, 0x608 and 0x610 respectively; pending bits stay set until cleared and further events accumulate.
- R3: The masked views at 0x04 (done), 0x0C (error 1) and 0x10 (error 2) read as the pending latch ANDed with that kind's mask.
- R4: The masks at 0x18 (done), 0x20 (error 1) and 0x24 (error 2) are read/write in their low NUM_CH bits; a 1 enables the channel, and the upper bits read zero.
- R5: Writing to 0x600, 0x608 or 0x610 clears each pending bit of that kind whose data bit is 1; zero bits and the other kinds are unaffected.
- R6: Bit i of the summary at 0x00 is 1 exactly when channel i has an enabled pending event of any kind.
- R7: `irq` is high one clock after the summary becomes nonzero and low one clock after it returns to zero.
- R8: When an event pulse and a clear write hit the same bit in the same cycle, the bit stays pending.
- R9: The priority word at 0x688 is DATA_W bits wide and reads back what was last written.
- R10: Offsets not listed above read zero, and writes to read-only offsets (0x00, 0x04, 0x0C, 0x10) change nothing.
- R11: Writing bit i to all three clear addresses removes every pending event of channel i and leaves other channels' events in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` |
| evt_done | input | NUM_CH | Per-channel transfer-done event pulses |
| evt_err1 | input | NUM_CH | Per-channel error-1 event pulses |
| evt_err2 | input | NUM_CH | Per-channel error-2 event pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest situation to reach from the ports is an event pulse landing on the very clock edge of a clear write to the same bit, since the two come from unrelated agents. The stimulus drives the event vector and the clear write on the same falling edge so both are sampled together, with one cleared bit also carrying a fresh event and another not. The interrupt latency is caught by enabling a mask only after the event is already pending, then sampling `irq` at the falling edges just after and one cycle after the mask write.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

  localparam int SRC_N = 3;

  typedef enum int {
    SRC_DONE = 0,
    SRC_ERR1 = 1,
    SRC_ERR2 = 2
  } src_e;

  localparam logic [11:0] OFS_SUMMARY = 12'h000;
  localparam logic [11:0] OFS_PRIO    = 12'h688;

  function automatic logic [11:0] ofs_view(input int s);
    case (s)
      SRC_DONE: ofs_view = 12'h004;
      SRC_ERR1: ofs_view = 12'h00C;
      default:  ofs_view = 12'h010;
    endcase
  endfunction

  function automatic logic [11:0] ofs_mask(input int s);
    case (s)
      SRC_DONE: ofs_mask = 12'h018;
      SRC_ERR1: ofs_mask = 12'h020;
      default:  ofs_mask = 12'h024;
    endcase
  endfunction

  function automatic logic [11:0] ofs_pend(input int s);
    case (s)
      SRC_DONE: ofs_pend = 12'h600;
      SRC_ERR1: ofs_pend = 12'h608;
      default:  ofs_pend = 12'h610;
    endcase
  endfunction

endpackage

// File: rtl/dma_irq_src.sv
module dma_irq_src #(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt_i,
  input  logic              mask_we_i,
  input  logic              clr_we_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] pend_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] view_o
);

  logic [NUM_CH-1:0] pend_q, pend_d;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] clr_vec;

  // Next state: clear first, then set, so an event on the same edge wins.
  always_comb begin
    clr_vec = clr_we_i ? wdata_i : '0;
    pend_d  = (pend_q & ~clr_vec) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we_i) begin
      mask_q <= wdata_i;
    end
  end

  assign pend_o = pend_q;
  assign mask_o = mask_q;
  assign view_o = pend_q & mask_q;

  // R8: an event pulse always leaves its bit pending on the next cycle
  assert_evt_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  // R5: cleared bits without a concurrent event are gone
  assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we_i |=> ((pend_q & $past(wdata_i & ~evt_i)) == '0));

  // R2: bits touched by neither event nor clear keep their value
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pend_q ^ $past(pend_q)) & ~$past(evt_i) & ~$past(clr_vec)) == '0));

  // R4: a mask write is visible on the next cycle
  assert_mask_wr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we_i |=> (mask_q == $past(wdata_i)));

endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                         reg_wr_i,
  input  logic [ADDR_W-1:0]            reg_addr_i,
  input  logic [SRC_N-1:0][NUM_CH-1:0] pend_i,
  input  logic [SRC_N-1:0][NUM_CH-1:0] mask_i,
  input  logic [SRC_N-1:0][NUM_CH-1:0] view_i,
  input  logic [NUM_CH-1:0]            summary_i,
  input  logic [DATA_W-1:0]            prio_i,
  output logic [SRC_N-1:0]             mask_we_o,
  output logic [SRC_N-1:0]             clr_we_o,
  output logic                         prio_we_o,
  output logic [DATA_W-1:0]            rdata_o
);

  // Write decode: only masks, clear addresses and priority are writable.
  always_comb begin
    for (int s = 0; s < SRC_N; s++) begin
      mask_we_o[s] = reg_wr_i && (reg_addr_i == ADDR_W'(ofs_mask(s)));
      clr_we_o[s]  = reg_wr_i && (reg_addr_i == ADDR_W'(ofs_pend(s)));
    end
    prio_we_o = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_PRIO));
  end

  // Read mux: unmapped offsets fall through to zero.
  always_comb begin
    rdata_o = '0;
    if (reg_addr_i == ADDR_W'(OFS_SUMMARY)) begin
      rdata_o[NUM_CH-1:0] = summary_i;
    end
    if (reg_addr_i == ADDR_W'(OFS_PRIO)) begin
      rdata_o = prio_i;
    end
    for (int s = 0; s < SRC_N; s++) begin
      if (reg_addr_i == ADDR_W'(ofs_view(s))) rdata_o[NUM_CH-1:0] = view_i[s];
      if (reg_addr_i == ADDR_W'(ofs_mask(s))) rdata_o[NUM_CH-1:0] = mask_i[s];
      if (reg_addr_i == ADDR_W'(ofs_pend(s))) rdata_o[NUM_CH-1:0] = pend_i[s];
    end
  end

endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [NUM_CH-1:0] evt_done,
  input  logic [NUM_CH-1:0] evt_err1,
  input  logic [NUM_CH-1:0] evt_err2,
  output logic              irq
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0]       rst_sync_q;
  logic                         rst_int_n;
  logic [SRC_N-1:0][NUM_CH-1:0] evt_vec;
  logic [SRC_N-1:0][NUM_CH-1:0] pend_vec, mask_vec, view_vec;
  logic [SRC_N-1:0]             mask_we, clr_we;
  logic                         prio_we;
  logic [DATA_W-1:0]            prio_q;
  logic [NUM_CH-1:0]            summary;
  logic                         irq_q, irq_d;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  assign evt_vec[SRC_DONE] = evt_done;
  assign evt_vec[SRC_ERR1] = evt_err1;
  assign evt_vec[SRC_ERR2] = evt_err2;

  for (genvar s = 0; s < SRC_N; s++) begin : g_src
    dma_irq_src #(.NUM_CH(NUM_CH)) u_src (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .evt_i     (evt_vec[s]),
      .mask_we_i (mask_we[s]),
      .clr_we_i  (clr_we[s]),
      .wdata_i   (reg_wdata[NUM_CH-1:0]),
      .pend_o    (pend_vec[s]),
      .mask_o    (mask_vec[s]),
      .view_o    (view_vec[s])
    );
  end

  always_comb begin
    summary = '0;
    for (int s = 0; s < SRC_N; s++) summary = summary | view_vec[s];
    irq_d = |summary;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      prio_q <= '0;
    end else if (prio_we) begin
      prio_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;

  dma_irq_regif #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .reg_wr_i   (reg_wr),
    .reg_addr_i (reg_addr),
    .pend_i     (pend_vec),
    .mask_i     (mask_vec),
    .view_i     (view_vec),
    .summary_i  (summary),
    .prio_i     (prio_q),
    .mask_we_o  (mask_we),
    .clr_we_o   (clr_we),
    .prio_we_o  (prio_we),
    .rdata_o    (reg_rdata)
  );

  // R7: a nonzero summary raises irq one cycle later
  assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (summary != '0) |=> irq);

  // R7: an all-zero summary drops irq one cycle later
  assert_irq_fall_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (summary == '0) |=> !irq);

  // R6: a summary bit can only be set for a channel with some enabled pending event
  assert_summary_src_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((summary & ~((pend_vec[0] & mask_vec[0]) | (pend_vec[1] & mask_vec[1])
                 | (pend_vec[2] & mask_vec[2]))) == '0));

  // R9: priority word holds when not written
  assert_prio_hold_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !prio_we |=> $stable(prio_q));

endmodule

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb;

  localparam int  NUM_CH = 16;
  localparam int  ADDR_W = 12;
  localparam int  DATA_W = 32;
  localparam time CLK_PERIOD = 10;

  logic              clk;
  logic              rst_n;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_wdata;
  logic [DATA_W-1:0] reg_rdata;
  logic [NUM_CH-1:0] evt_done, evt_err1, evt_err2;
  logic              irq;

  int checks = 0;
  int errors = 0;

  dma_irq_agg #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_done(evt_done),
    .evt_err1(evt_err1), .evt_err2(evt_err2), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [15:0] dn, input logic [15:0] e1, input logic [15:0] e2);
    @(negedge clk);
    evt_done = dn; evt_err1 = e1; evt_err2 = e2;
    @(negedge clk);
    evt_done = '0; evt_err1 = '0; evt_err2 = '0;
  endtask

  task automatic clear_all();
    wr(12'h600, 32'hFFFF);
    wr(12'h608, 32'hFFFF);
    wr(12'h610, 32'hFFFF);
    wr(12'h018, 32'h0);
    wr(12'h020, 32'h0);
    wr(12'h024, 32'h0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rd(12'h600, d); chk("R1", "pend done in reset", d, 0);
    chk("R1", "irq in reset", {31'd0, irq}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(12'h000, d); chk("R1", "summary after reset", d, 0);
    rd(12'h018, d); chk("R1", "mask done after reset", d, 0);
    rd(12'h688, d); chk("R1", "prio after reset", d, 0);
    chk("R1", "irq after reset", {31'd0, irq}, 0);
  endtask

  task automatic t_latch();
    logic [31:0] d;
    clear_all();
    pulse(16'h0005, 16'h8000, 16'h0000);
    rd(12'h600, d); chk("R2", "pend done", d, 32'h0005);
    rd(12'h608, d); chk("R2", "pend err1", d, 32'h8000);
    rd(12'h610, d); chk("R2", "pend err2", d, 32'h0000);
    pulse(16'h0100, 16'h0, 16'h0);
    rd(12'h600, d); chk("R2", "pend done sticky", d, 32'h0105);
  endtask

  task automatic t_views();
    logic [31:0] d;
    clear_all();
    pulse(16'h0005, 16'h8000, 16'h0002);
    wr(12'h018, 32'h0001);
    rd(12'h004, d); chk("R3", "view done", d, 32'h0001);
    rd(12'h00C, d); chk("R3", "view err1 masked", d, 32'h0);
    rd(12'h000, d); chk("R6", "summary done only", d, 32'h0001);
    wr(12'h020, 32'hFFFF);
    rd(12'h00C, d); chk("R3", "view err1", d, 32'h8000);
    wr(12'h024, 32'h0002);
    rd(12'h010, d); chk("R3", "view err2", d, 32'h0002);
    rd(12'h000, d); chk("R6", "summary all kinds", d, 32'h8003);
    wr(12'h018, 32'hABCD1234);
    rd(12'h018, d); chk("R4", "mask done upper bits", d, 32'h1234);
    rd(12'h020, d); chk("R4", "mask err1", d, 32'hFFFF);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    clear_all();
    pulse(16'h0105, 16'h8000, 16'h0001);
    wr(12'h600, 32'h0004);
    rd(12'h600, d); chk("R5", "clear one bit", d, 32'h0101);
    wr(12'h600, 32'h0);
    rd(12'h600, d); chk("R5", "zero write no effect", d, 32'h0101);
    rd(12'h608, d); chk("R5", "other kind untouched", d, 32'h8000);
    rd(12'h610, d); chk("R5", "err2 untouched", d, 32'h0001);
  endtask

  task automatic t_race();
    logic [31:0] d;
    clear_all();
    pulse(16'h0001, 16'h0, 16'h0);
    @(negedge clk);
    evt_done = 16'h0004; reg_wr = 1'b1; reg_addr = 12'h600; reg_wdata = 32'h0005;
    @(negedge clk);
    evt_done = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(12'h600, d); chk("R8", "event beats clear", d, 32'h0004);
  endtask

  task automatic t_irq();
    clear_all();
    @(negedge clk);
    chk("R7", "irq idle", {31'd0, irq}, 0);
    pulse(16'h0, 16'h0, 16'h0008);
    @(negedge clk);
    chk("R7", "masked event no irq", {31'd0, irq}, 0);
    wr(12'h024, 32'h0008);
    chk("R7", "irq not yet after mask", {31'd0, irq}, 0);
    @(negedge clk);
    chk("R7", "irq one cycle after", {31'd0, irq}, 1);
    wr(12'h610, 32'h0008);
    chk("R7", "irq still high right after clear", {31'd0, irq}, 1);
    @(negedge clk);
    chk("R7", "irq low after clear", {31'd0, irq}, 0);
  endtask

  task automatic t_prio();
    logic [31:0] d;
    wr(12'h688, 32'hDEADBEEF);
    rd(12'h688, d); chk("R9", "prio readback", d, 32'hDEADBEEF);
    wr(12'h688, 32'h0);
    rd(12'h688, d); chk("R9", "prio zero", d, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    clear_all();
    pulse(16'h0003, 16'h0, 16'h0);
    wr(12'h018, 32'h0001);
    rd(12'h700, d); chk("R10", "unmapped 0x700", d, 0);
    rd(12'h014, d); chk("R10", "unmapped 0x014", d, 0);
    rd(12'h604, d); chk("R10", "unmapped 0x604", d, 0);
    wr(12'h000, 32'hFFFF);
    rd(12'h000, d); chk("R10", "summary write ignored", d, 32'h0001);
    wr(12'h004, 32'hFFFF);
    rd(12'h600, d); chk("R10", "view write ignored", d, 32'h0003);
    rd(12'h018, d); chk("R10", "mask after view write", d, 32'h0001);
  endtask

  task automatic t_terminate();
    logic [31:0] d;
    clear_all();
    pulse(16'h0060, 16'h0060, 16'h0060);
    wr(12'h600, 32'h0020);
    wr(12'h608, 32'h0020);
    wr(12'h610, 32'h0020);
    rd(12'h600, d); chk("R11", "done ch5 gone ch6 kept", d, 32'h0040);
    rd(12'h608, d); chk("R11", "err1 ch5 gone ch6 kept", d, 32'h0040);
    rd(12'h610, d); chk("R11", "err2 ch5 gone ch6 kept", d, 32'h0040);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    evt_done = '0; evt_err1 = '0; evt_err2 = '0;
    t_reset();
    t_latch();
    t_views();
    t_w1c();
    t_race();
    t_irq();
    t_prio();
    t_unmapped();
    t_terminate();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule